// File: doc/BRIEF.md
# Single-Error Hamming Sector Code Engine

This block produces and checks a 24-bit single-error-correcting code for each fixed-size data sector of a NAND page. Data bytes stream in one per cycle. Each byte is steered to one of several per-chip-select parity lanes, so several sectors on different chip selects can be built up at the same time. A lane is armed by a restart pulse. From then on it counts the bytes of its sector and folds each one into twelve "index bit set" parities and twelve "index bit clear" parities. The index here is the 12-bit position {byte number, bit number} of every data bit. A fetch returns the lane's code, inverted and packed as three bytes, and leaves the lane empty and disarmed.

On readback, software hands the stored code and the freshly computed code to the comparison side. It classifies the pair as clean, a single flipped data bit (with the byte and bit to patch), a single flipped bit inside the stored code, or uncorrectable. The block only reports where to patch. The data buffer belongs to the caller.

Top module: `hecc_engine`

## Requirements
- R1: While reset is held and right after it, `code_valid` and `res_valid` are 0.
- R2: The code is `~{hi[11:0], lo[11:0]}`. Byte 0 of the stored form is code bits 7:0, byte 1 is bits 15:8 and byte 2 is bits 23:16. A full sector of 0xFF bytes gives 0xFFFFFF.
- R3: For every data bit set at byte n, bit b, take the position p = {n[8:0], b[2:0]}. For each k in 0..11, the bit toggles hi[k] when p[k] is 1 and lo[k] when p[k] is 0.
- R4: A byte with `din_valid` high goes only to the lane selected by `sel_cs`. Lanes do not affect one another.
- R5: A fetch (`rd_req` with `rd_cs`) presents that lane's code on `code` with `code_valid` high one cycle later. The fetch then clears the lane and disarms it. A disarmed lane ignores data, so a later fetch gives 0xFFFFFF.
- R6: Bit i of `start_mask` clears lane i, arms it and restarts its byte count at 0, even in the middle of a sector.
- R7: An armed lane takes at most SECTOR_BYTES bytes. Any further bytes are ignored until the next restart.
- R8: A compare with `stored_code == calc_code` reports `res_kind` 0 (clean).
- R9: If d = stored ^ calc has d[23:12] ^ d[11:0] == 0xFFF and d[23:15] < SECTOR_BYTES, the report is `res_kind` 1 with `res_byte` = d[23:15] and `res_bit` = d[14:12].
- R10: If the halves of d are complementary but d[23:15] >= SECTOR_BYTES, the report is `res_kind` 3 (uncorrectable).
- R11: If exactly one bit of d is set, the report is `res_kind` 2 (error in the stored code, no data change), with `res_byte` and `res_bit` 0.
- R12: Any other nonzero d reports `res_kind` 3. `res_byte` and `res_bit` are 0 for every kind other than 1.
- R13: A compare result appears with `res_valid` high exactly one cycle after `cmp_valid`, and `res_valid` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_mask | input | NUM_CS | Per-lane restart and arm |
| din_valid | input | 1 | Data byte present |
| sel_cs | input | CS_W | Lane receiving the byte |
| din | input | 8 | Data byte |
| rd_req | input | 1 | Fetch and clear a lane |
| rd_cs | input | CS_W | Lane to fetch |
| code_valid | output | 1 | Fetched code present |
| code | output | 24 | Inverted packed code |
| cmp_valid | input | 1 | Compare request |
| stored_code | input | 24 | Code read from flash |
| calc_code | input | 24 | Code computed on readback |
| res_valid | output | 1 | Compare result present |
| res_kind | output | 2 | 0 clean, 1 data fix, 2 code-only, 3 uncorrectable |
| res_byte | output | 9 | Byte to patch |
| res_bit | output | 3 | Bit to patch |

## Verification
The hardest case to reach is a difference whose halves are exact complements but whose byte index lies beyond the sector. With a full 512-byte sector, a 9-bit index can never be out of range. The bench therefore builds a second instance with a 256-byte sector and feeds it complementary-half differences for bytes above and below that limit. Data-bit errors are not built by hand. The bench flips one or two random bits of a random sector and recomputes the code with its own model, so the classifier sees the differences a real single-bit or double-bit upset would produce.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
  localparam int COL_BITS  = 3;
  localparam int LINE_BITS = 9;
  localparam int HALF_W    = COL_BITS + LINE_BITS;
  localparam int CODE_W    = 2 * HALF_W;

  typedef enum logic [1:0] {
    CHK_CLEAN     = 2'd0,
    CHK_DATA_FIX  = 2'd1,
    CHK_CODE_ONLY = 2'd2,
    CHK_BAD       = 2'd3
  } chk_kind_t;
endpackage

// File: rtl/hecc_lane.sv
module hecc_lane
  import hecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int CNT_W = $clog2(SECTOR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic              feed_i,
  input  logic [7:0]        byte_i,
  input  logic              fetch_i,
  output logic [HALF_W-1:0] lo_o,
  output logic [HALF_W-1:0] hi_o
);
  logic [HALF_W-1:0]    lo_q, hi_q, lo_d, hi_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 armed_q, armed_d;
  logic                 accept, upd_en, bpar;
  logic [LINE_BITS-1:0] idx;

  assign accept = feed_i && armed_q && (cnt_q < CNT_W'(SECTOR_BYTES));
  assign upd_en = restart_i || fetch_i || accept;
  assign bpar   = ^byte_i;
  assign idx    = LINE_BITS'(cnt_q);

  always_comb begin
    lo_d    = lo_q;
    hi_d    = hi_q;
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (restart_i) begin
      lo_d    = '0;
      hi_d    = '0;
      cnt_d   = '0;
      armed_d = 1'b1;
    end else if (fetch_i) begin
      lo_d    = '0;
      hi_d    = '0;
      cnt_d   = '0;
      armed_d = 1'b0;
    end else if (accept) begin
      for (int k = 0; k < COL_BITS; k++) begin
        for (int j = 0; j < 8; j++) begin
          if (byte_i[j]) begin
            if (((j >> k) & 1) == 1) hi_d[k] = ~hi_d[k];
            else                     lo_d[k] = ~lo_d[k];
          end
        end
      end
      for (int k = 0; k < LINE_BITS; k++) begin
        if (idx[k]) hi_d[COL_BITS+k] = hi_d[COL_BITS+k] ^ bpar;
        else        lo_d[COL_BITS+k] = lo_d[COL_BITS+k] ^ bpar;
      end
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (upd_en) begin
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  // R5: a fetch without restart leaves the lane empty
  p_fetch_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_i && !restart_i) |=> (lo_o == '0 && hi_o == '0));

  // R5: a disarmed lane holds no parity
  p_disarmed_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (lo_o == '0 && hi_o == '0));

  // R7: byte count never passes the sector size
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(SECTOR_BYTES));
endmodule

// File: rtl/hecc_pack.sv
module hecc_pack
  import hecc_pkg::*;
(
  input  logic [HALF_W-1:0] lo_i,
  input  logic [HALF_W-1:0] hi_i,
  output logic [CODE_W-1:0] code_o
);
  // inversion makes an all-ones sector read back as a matching code
  assign code_o = ~{hi_i, lo_i};
endmodule

// File: rtl/hecc_judge.sv
module hecc_judge
  import hecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmp_valid,
  input  logic [CODE_W-1:0]    stored_code,
  input  logic [CODE_W-1:0]    calc_code,
  output logic                 res_valid,
  output logic [1:0]           res_kind,
  output logic [LINE_BITS-1:0] res_byte,
  output logic [COL_BITS-1:0]  res_bit
);
  logic [CODE_W-1:0]    diff;
  logic [HALF_W-1:0]    fold;
  logic [LINE_BITS-1:0] byte_idx;
  logic [COL_BITS-1:0]  bit_idx;
  chk_kind_t            kind_d, kind_q;
  logic [LINE_BITS-1:0] byte_d, byte_q;
  logic [COL_BITS-1:0]  bit_d, bit_q;
  logic                 valid_q;

  assign diff     = stored_code ^ calc_code;
  assign fold     = diff[CODE_W-1:HALF_W] ^ diff[HALF_W-1:0];
  assign byte_idx = diff[CODE_W-1:HALF_W+COL_BITS];
  assign bit_idx  = diff[HALF_W+COL_BITS-1:HALF_W];

  always_comb begin
    kind_d = CHK_BAD;
    byte_d = '0;
    bit_d  = '0;
    if (diff == '0) begin
      kind_d = CHK_CLEAN;
    end else if (fold == '1) begin
      if (int'(byte_idx) < SECTOR_BYTES) begin
        kind_d = CHK_DATA_FIX;
        byte_d = byte_idx;
        bit_d  = bit_idx;
      end
    end else if ($countones(diff) == 1) begin
      kind_d = CHK_CODE_ONLY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= cmp_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= CHK_CLEAN;
      byte_q <= '0;
      bit_q  <= '0;
    end else if (cmp_valid) begin
      kind_q <= kind_d;
      byte_q <= byte_d;
      bit_q  <= bit_d;
    end
  end

  assign res_valid = valid_q;
  assign res_kind  = kind_q;
  assign res_byte  = byte_q;
  assign res_bit   = bit_q;

  // R8: a clean report only follows identical codes
  p_clean_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == CHK_CLEAN) |-> $past(stored_code == calc_code));

  // R11: a code-only report only follows a one-bit difference
  p_code_only_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == CHK_CODE_ONLY) |-> $past($countones(stored_code ^ calc_code) == 1));

  // R10: a data patch location always lies inside the sector
  p_fix_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == CHK_DATA_FIX) |-> (int'(res_byte) < SECTOR_BYTES));

  // R13: a result follows a request by one cycle
  p_result_latency_r13: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(cmp_valid));
endmodule

// File: rtl/hecc_engine.sv
module hecc_engine
  import hecc_pkg::*;
#(
  parameter int NUM_CS       = 4,
  parameter int SECTOR_BYTES = 512,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CS-1:0] start_mask,
  input  logic              din_valid,
  input  logic [CS_W-1:0]   sel_cs,
  input  logic [7:0]        din,
  input  logic              rd_req,
  input  logic [CS_W-1:0]   rd_cs,
  output logic              code_valid,
  output logic [23:0]       code,
  input  logic              cmp_valid,
  input  logic [23:0]       stored_code,
  input  logic [23:0]       calc_code,
  output logic              res_valid,
  output logic [1:0]        res_kind,
  output logic [8:0]        res_byte,
  output logic [2:0]        res_bit
);
  logic              rst_meta_n, rst_q_n;
  logic [HALF_W-1:0] lo_w [NUM_CS];
  logic [HALF_W-1:0] hi_w [NUM_CS];
  logic [HALF_W-1:0] lo_sel, hi_sel;
  logic [CODE_W-1:0] code_d, code_q;
  logic              cv_q;

  // reset asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_lane
    hecc_lane #(.SECTOR_BYTES(SECTOR_BYTES)) u_lane (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .restart_i(start_mask[i]),
      .feed_i   (din_valid && (sel_cs == CS_W'(i))),
      .byte_i   (din),
      .fetch_i  (rd_req && (rd_cs == CS_W'(i))),
      .lo_o     (lo_w[i]),
      .hi_o     (hi_w[i])
    );
  end

  always_comb begin
    lo_sel = '0;
    hi_sel = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (rd_cs == CS_W'(i)) begin
        lo_sel = lo_w[i];
        hi_sel = hi_w[i];
      end
    end
  end

  hecc_pack u_pack (
    .lo_i  (lo_sel),
    .hi_i  (hi_sel),
    .code_o(code_d)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) cv_q <= 1'b0;
    else          cv_q <= rd_req;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    code_q <= '0;
    else if (rd_req) code_q <= code_d;
  end

  assign code_valid = cv_q;
  assign code       = code_q;

  hecc_judge #(.SECTOR_BYTES(SECTOR_BYTES)) u_judge (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .cmp_valid  (cmp_valid),
    .stored_code(stored_code),
    .calc_code  (calc_code),
    .res_valid  (res_valid),
    .res_kind   (res_kind),
    .res_byte   (res_byte),
    .res_bit    (res_bit)
  );

  // R5: fetched code appears one cycle after the request
  p_code_latency_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    code_valid |-> $past(rd_req));

  // R2: code is stable while no fetch is issued
  p_code_hold_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !$past(rd_req) |-> $stable(code));
endmodule

// File: tb/hecc_engine_test.sv
module hecc_engine_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  start_mask;
  logic        din_valid;
  logic [1:0]  sel_cs;
  logic [7:0]  din;
  logic        rd_req;
  logic [1:0]  rd_cs;
  logic        code_valid;
  logic [23:0] code;
  logic        cmp_valid;
  logic [23:0] stored_code, calc_code;
  logic        res_valid;
  logic [1:0]  res_kind;
  logic [8:0]  res_byte;
  logic [2:0]  res_bit;

  logic        s_cmp_valid;
  logic [23:0] s_stored, s_calc;
  logic        s_code_valid, s_res_valid;
  logic [23:0] s_code;
  logic [1:0]  s_res_kind;
  logic [8:0]  s_res_byte;
  logic [2:0]  s_res_bit;

  int nchk = 0;
  int nfail = 0;
  logic [7:0] bank [2][512];

  always #2 clk = ~clk;

  hecc_engine uut (
    .clk(clk), .rst_n(rst_n), .start_mask(start_mask), .din_valid(din_valid),
    .sel_cs(sel_cs), .din(din), .rd_req(rd_req), .rd_cs(rd_cs),
    .code_valid(code_valid), .code(code), .cmp_valid(cmp_valid),
    .stored_code(stored_code), .calc_code(calc_code), .res_valid(res_valid),
    .res_kind(res_kind), .res_byte(res_byte), .res_bit(res_bit)
  );

  hecc_engine #(.SECTOR_BYTES(256)) uut_small (
    .clk(clk), .rst_n(rst_n), .start_mask(4'b0), .din_valid(1'b0),
    .sel_cs(2'd0), .din(8'd0), .rd_req(1'b0), .rd_cs(2'd0),
    .code_valid(s_code_valid), .code(s_code), .cmp_valid(s_cmp_valid),
    .stored_code(s_stored), .calc_code(s_calc), .res_valid(s_res_valid),
    .res_kind(s_res_kind), .res_byte(s_res_byte), .res_bit(s_res_bit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_code(input int which, input int len);
    logic [11:0] hi = '0;
    logic [11:0] lo = '0;
    for (int n = 0; n < len; n++) begin
      for (int b = 0; b < 8; b++) begin
        if (bank[which][n][b]) begin
          logic [11:0] p = {n[8:0], b[2:0]};
          for (int k = 0; k < 12; k++) begin
            if (p[k]) hi[k] = ~hi[k];
            else      lo[k] = ~lo[k];
          end
        end
      end
    end
    return ~{hi, lo};
  endfunction

  // returns {kind, byte, bit}
  function automatic logic [13:0] ref_judge(input logic [23:0] s, input logic [23:0] c, input int sb);
    logic [23:0] d = s ^ c;
    if (d == 0) return {2'd0, 12'd0};
    if ((d[23:12] ^ d[11:0]) == 12'hfff) begin
      if (int'(d[23:15]) < sb) return {2'd1, d[23:15], d[14:12]};
      return {2'd3, 12'd0};
    end
    if ($countones(d) == 1) return {2'd2, 12'd0};
    return {2'd3, 12'd0};
  endfunction

  task automatic send(input logic [1:0] cs, input logic [7:0] b);
    din_valid = 1'b1; sel_cs = cs; din = b;
    @(negedge clk);
    din_valid = 1'b0;
  endtask

  task automatic restart(input logic [3:0] m);
    start_mask = m;
    @(negedge clk);
    start_mask = '0;
  endtask

  task automatic fetch(input logic [1:0] cs, output logic [23:0] got, output logic vld);
    rd_req = 1'b1; rd_cs = cs;
    @(negedge clk);
    rd_req = 1'b0;
    got = code; vld = code_valid;
  endtask

  task automatic compare(input string req, input logic [23:0] s, input logic [23:0] c);
    logic [13:0] e = ref_judge(s, c, 512);
    cmp_valid = 1'b1; stored_code = s; calc_code = c;
    @(negedge clk);
    cmp_valid = 1'b0;
    chk({req, " R13 valid"}, {31'd0, res_valid}, 32'd1);
    chk({req, " kind"}, {30'd0, res_kind}, {30'd0, e[13:12]});
    chk({req, " byte"}, {23'd0, res_byte}, {23'd0, e[11:3]});
    chk({req, " bit"},  {29'd0, res_bit},  {29'd0, e[2:0]});
  endtask

  task automatic compare_small(input string req, input logic [23:0] s, input logic [23:0] c);
    logic [13:0] e = ref_judge(s, c, 256);
    s_cmp_valid = 1'b1; s_stored = s; s_calc = c;
    @(negedge clk);
    s_cmp_valid = 1'b0;
    chk({req, " kind"}, {30'd0, s_res_kind}, {30'd0, e[13:12]});
    chk({req, " byte"}, {23'd0, s_res_byte}, {23'd0, e[11:3]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [23:0] got, c0, c1;
    logic vld;
    void'($urandom(32'h1234abcd));
    rst_n = 1'b0; start_mask = '0; din_valid = 1'b0; sel_cs = '0; din = '0;
    rd_req = 1'b0; rd_cs = '0; cmp_valid = 1'b0; stored_code = '0; calc_code = '0;
    s_cmp_valid = 1'b0; s_stored = '0; s_calc = '0;
    repeat (4) @(negedge clk);
    chk("R1 code_valid in reset", {31'd0, code_valid}, 32'd0);
    chk("R1 res_valid in reset", {31'd0, res_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 code_valid after reset", {31'd0, code_valid}, 32'd0);
    chk("R1 res_valid after reset", {31'd0, res_valid}, 32'd0);

    // R2: erased sector
    restart(4'b0001);
    for (int i = 0; i < 512; i++) send(2'd0, 8'hff);
    fetch(2'd0, got, vld);
    chk("R5 code_valid", {31'd0, vld}, 32'd1);
    chk("R2 erased code", {8'd0, got}, 32'hffffff);
    @(negedge clk);
    chk("R5 code_valid drops", {31'd0, code_valid}, 32'd0);

    // R3/R4: two lanes interleaved
    for (int i = 0; i < 512; i++) begin
      bank[0][i] = 8'($urandom);
      bank[1][i] = 8'($urandom);
    end
    restart(4'b0110);
    for (int i = 0; i < 512; i++) begin
      send(2'd1, bank[0][i]);
      send(2'd2, bank[1][i]);
    end
    fetch(2'd2, got, vld);
    chk("R4 lane2 code", {8'd0, got}, {8'd0, ref_code(1, 512)});
    fetch(2'd1, got, vld);
    chk("R3 lane1 code", {8'd0, got}, {8'd0, ref_code(0, 512)});

    // R5: cleared and disarmed
    fetch(2'd1, got, vld);
    chk("R5 cleared after fetch", {8'd0, got}, 32'hffffff);
    for (int i = 0; i < 10; i++) send(2'd1, 8'h5a);
    fetch(2'd1, got, vld);
    chk("R5 disarmed ignores data", {8'd0, got}, 32'hffffff);

    // R6: restart mid-sector
    restart(4'b1000);
    for (int i = 0; i < 100; i++) send(2'd3, 8'($urandom));
    for (int i = 0; i < 200; i++) bank[0][i] = 8'($urandom);
    restart(4'b1000);
    for (int i = 0; i < 200; i++) send(2'd3, bank[0][i]);
    fetch(2'd3, got, vld);
    chk("R6 restart mid-sector", {8'd0, got}, {8'd0, ref_code(0, 200)});

    // R7: bytes past the sector end
    for (int i = 0; i < 512; i++) bank[0][i] = 8'($urandom);
    restart(4'b0001);
    for (int i = 0; i < 512; i++) send(2'd0, bank[0][i]);
    for (int i = 0; i < 20; i++) send(2'd0, 8'($urandom));
    fetch(2'd0, got, vld);
    chk("R7 extra bytes ignored", {8'd0, got}, {8'd0, ref_code(0, 512)});

    // R8 clean
    for (int t = 0; t < 4; t++) begin
      logic [23:0] x = 24'($urandom);
      compare("R8 clean", x, x);
    end
    compare("R8 erased clean", 24'hffffff, 24'hffffff);

    // R9 single data bit flips
    for (int i = 0; i < 512; i++) bank[0][i] = 8'($urandom);
    c0 = ref_code(0, 512);
    for (int t = 0; t < 6; t++) begin
      int n = int'($urandom % 512);
      int b = int'($urandom % 8);
      if (t == 0) begin n = 511; b = 7; end
      if (t == 1) begin n = 0; b = 0; end
      bank[0][n][b] = ~bank[0][n][b];
      c1 = ref_code(0, 512);
      bank[0][n][b] = ~bank[0][n][b];
      compare("R9 data flip", c0, c1);
      chk("R9 byte index", {23'd0, res_byte}, n);
      chk("R9 bit index", {29'd0, res_bit}, b);
    end

    // R11 code-only flips
    for (int t = 0; t < 6; t++) begin
      int r = int'($urandom % 24);
      compare("R11 code flip", c0, c0 ^ (24'd1 << r));
    end

    // R12 double data flips and random differences
    for (int t = 0; t < 4; t++) begin
      int n1 = int'($urandom % 256);
      int n2 = 256 + int'($urandom % 256);
      bank[0][n1][1] = ~bank[0][n1][1];
      bank[0][n2][6] = ~bank[0][n2][6];
      c1 = ref_code(0, 512);
      bank[0][n1][1] = ~bank[0][n1][1];
      bank[0][n2][6] = ~bank[0][n2][6];
      compare("R12 double flip", c0, c1);
      chk("R12 double flip kind", {30'd0, res_kind}, 32'd3);
    end
    for (int t = 0; t < 8; t++) compare("R12 random diff", 24'($urandom), 24'($urandom));
    @(negedge clk);
    chk("R13 valid low when idle", {31'd0, res_valid}, 32'd0);

    // R10 index beyond a 256-byte sector
    begin
      logic [11:0] p;
      p = {9'd300, 3'd5};
      compare_small("R10 out of range", 24'd0, {p, ~p});
      chk("R10 kind bad", {30'd0, s_res_kind}, 32'd3);
      p = {9'd100, 3'd2};
      compare_small("R10 in range", 24'd0, {p, ~p});
      chk("R10 in range kind", {30'd0, s_res_kind}, 32'd1);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule